// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This block turns one host request into the full sequence of bus primitives for a memory-style I2C transfer: a presence probe, a read from a register or memory location, or a write to one. It sits above a bit-level master. The host gives it a 7-bit device address, a memory address of zero to four bytes with its length, a byte count and a choice of restart style. The sequencer then hands START, STOP, byte-write and byte-read commands to the bit engine one at a time. It waits for each one to complete before it issues the next.

Write data comes in on a valid/ready byte stream and read data goes out on another. Each stream holds at most one byte inside the block. When a transfer finishes, the block pulses `done`. The outcome stays on `err`, `present` and `fail_cnt` until the next request starts. For parts that put high memory-address bits in the device address, a mask input folds those bits into the device address before the first byte goes out.

Top module: `i2c_mem_seq`

## Requirements
- R1: A probe (`op`=00) issues START, then the byte {dev_addr,0}, then STOP. `present` is 1 only if that byte was acknowledged. A NACK sets `err`.
- R2: The command port uses the codes 0=START, 1=STOP, 2=WRITE (byte on `cmd_byte`), 3=READ (`cmd_nack` gives the acknowledge bit to drive). A command stays stable until `cmd_ready` takes it. The block issues no further command until `cmd_done` arrives.
- R3: A write (`op`=1x), and the pointer phase of a read, start with START and {dev,0}. If that byte is NACKed, the block sends STOP and ends with `err`=1.
- R4: Memory address bytes go out most significant byte first. Exactly `alen` of them are sent.
- R5: A NACK on any memory address byte ends the transfer with `err`=1 and sends no STOP.
- R6: Each NACKed write data byte adds one to `fail_cnt`. The remaining bytes are still sent, STOP follows the last one, and `err` stays 0.
- R7: A read (`op`=01) with `alen`=0 goes from START straight to {dev,1}.
- R8: A read with `alen`>0 ends the pointer phase with STOP then START when `rep_start`=0, and with START alone when `rep_start`=1.
- R9: In the read phase, every READ command asks for an ACK (`cmd_nack`=0) except the last, which asks for a NACK. STOP follows. The acknowledge of the {dev,1} byte is ignored.
- R10: A read with `nbytes`=0 sends {dev,1} and then STOP at once.
- R11: For reads and writes, `dev_addr` is ORed with (`mem_addr` >> 8*`alen`)[6:0] masked by `ovf_mask`. A probe ignores the mask.
- R12: Each read byte is offered on `rd_data` with `rd_valid` held until `rd_ready`. No bus command is issued while a byte is waiting.
- R13: `done` is a one-cycle pulse after which `busy` is low. `err`, `present` and `fail_cnt` hold their values until the next `start`. While idle, no command, read byte or write request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| op | input | 2 | 00 probe, 01 read, 1x write |
| dev_addr | input | 7 | 7-bit device address |
| mem_addr | input | 8*MAX_ALEN | Memory address |
| alen | input | AL_W | Number of memory address bytes |
| nbytes | input | CNT_W | Data byte count |
| rep_start | input | 1 | Repeated START before read phase |
| ovf_mask | input | 7 | Overflow bits to fold into device address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Transfer aborted |
| present | output | 1 | Probe result |
| fail_cnt | output | FAIL_W | NACKed write data bytes |
| cmd_valid | output | 1 | Command to bit engine valid |
| cmd_ready | input | 1 | Bit engine takes command |
| cmd_op | output | 2 | Command code |
| cmd_byte | output | 8 | Byte to write |
| cmd_nack | output | 1 | Acknowledge bit to send after a read |
| cmd_done | input | 1 | Command finished |
| done_nack | input | 1 | Acknowledge seen on a written byte (1 = NACK) |
| done_rdata | input | 8 | Byte read by the engine |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |

## Verification
The assertions watch the handshakes on every cycle. A command or read byte waiting for its partner must stay unchanged. The block must be silent while idle, `done` must be a single pulse, and the failure count must never fall during a transfer. Only the bench scenarios can show that the commands come in the right order with the right bytes. That covers the abort paths with and without STOP, the two restart styles, the ACK/NACK pattern of the read phase, the zero-length cases and the folding of overflow bits into the device address. The scenarios also cover counting of write NACKs without aborting.

// File: rtl/i2c_mem_seq.sv
module i2c_mem_seq #(
  parameter int MAX_ALEN = 4,
  parameter int CNT_W = 8,
  parameter int FAIL_W = 8,
  localparam int AL_W = $clog2(MAX_ALEN + 1),
  localparam int MA_W = 8 * MAX_ALEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [6:0]        dev_addr,
  input  logic [MA_W-1:0]   mem_addr,
  input  logic [AL_W-1:0]   alen,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic              rep_start,
  input  logic [6:0]        ovf_mask,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              present,
  output logic [FAIL_W-1:0] fail_cnt,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [7:0]        cmd_byte,
  output logic              cmd_nack,
  input  logic              cmd_done,
  input  logic              done_nack,
  input  logic [7:0]        done_rdata,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data
);
  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_WRITE = 2'd2, C_READ = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_START1, S_DEVW, S_MADDR, S_MSTOP, S_START2,
    S_DEVR, S_RDATA, S_RPUSH, S_WDATA, S_STOP, S_FIN
  } state_t;

  state_t st;
  logic [1:0] op_q;
  logic [6:0] dev_q;
  logic [MA_W-1:0] addr_q;
  logic [AL_W-1:0] alen_q, idx;
  logic [CNT_W-1:0] rem;
  logic rep_q, wt, have;
  logic [7:0] wbyte, rdbuf;
  logic c_has;

  wire is_rd = (op_q == 2'b01);
  wire is_probe = (op_q == 2'b00);

  logic [MA_W-1:0] hi_bits;
  assign hi_bits = mem_addr >> (8 * int'(alen));
  wire [6:0] dev_fold = (op == 2'b00) ? dev_addr : (dev_addr | (hi_bits[6:0] & ovf_mask));

  always_comb begin
    c_has = 1'b1;
    cmd_op = C_WRITE;
    cmd_byte = 8'h00;
    cmd_nack = 1'b0;
    case (st)
      S_START1, S_START2: cmd_op = C_START;
      S_MSTOP, S_STOP:    cmd_op = C_STOP;
      S_DEVW:  cmd_byte = {dev_q, 1'b0};
      S_DEVR:  cmd_byte = {dev_q, 1'b1};
      S_MADDR: cmd_byte = addr_q[8*int'(idx) +: 8];
      S_WDATA: cmd_byte = wbyte;
      S_RDATA: begin
        cmd_op = C_READ;
        cmd_nack = (rem == CNT_W'(1));
      end
      default: c_has = 1'b0;
    endcase
  end

  assign cmd_valid = c_has && !wt && (st != S_WDATA || have);
  assign busy = (st != S_IDLE);
  assign done = (st == S_FIN);
  assign rd_valid = (st == S_RPUSH);
  assign rd_data = rdbuf;
  assign wr_ready = (st == S_WDATA) && !have;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= 2'b00;
      dev_q <= '0;
      addr_q <= '0;
      alen_q <= '0;
      idx <= '0;
      rem <= '0;
      rep_q <= 1'b0;
      wt <= 1'b0;
      have <= 1'b0;
      wbyte <= '0;
      rdbuf <= '0;
      err <= 1'b0;
      present <= 1'b0;
      fail_cnt <= '0;
    end else if (st == S_IDLE) begin
      if (start) begin
        op_q <= op;
        dev_q <= dev_fold;
        addr_q <= mem_addr;
        alen_q <= alen;
        rem <= nbytes;
        rep_q <= rep_start;
        err <= 1'b0;
        present <= 1'b0;
        fail_cnt <= '0;
        wt <= 1'b0;
        have <= 1'b0;
        st <= S_START1;
      end
    end else begin
      if (cmd_valid && cmd_ready) wt <= 1'b1;
      if (st == S_WDATA && !have && wr_valid) begin
        wbyte <= wr_data;
        have <= 1'b1;
      end
      if (st == S_RPUSH && rd_ready) st <= (rem == '0) ? S_STOP : S_RDATA;
      if (st == S_FIN) st <= S_IDLE;
      if (wt && cmd_done) begin
        wt <= 1'b0;
        case (st)
          S_START1: st <= (is_rd && alen_q == '0) ? S_DEVR : S_DEVW;
          S_DEVW: begin
            if (done_nack) begin
              err <= 1'b1;
              st <= S_STOP;
            end else if (is_probe) begin
              present <= 1'b1;
              st <= S_STOP;
            end else if (alen_q != '0) begin
              idx <= alen_q - 1'b1;
              st <= S_MADDR;
            end else begin
              st <= (rem == '0) ? S_STOP : S_WDATA;
            end
          end
          S_MADDR: begin
            if (done_nack) begin
              err <= 1'b1;
              st <= S_FIN;
            end else if (idx != '0) begin
              idx <= idx - 1'b1;
            end else if (is_rd) begin
              st <= rep_q ? S_START2 : S_MSTOP;
            end else begin
              st <= (rem == '0) ? S_STOP : S_WDATA;
            end
          end
          S_MSTOP:  st <= S_START2;
          S_START2: st <= S_DEVR;
          S_DEVR:   st <= (rem == '0) ? S_STOP : S_RDATA;
          S_RDATA: begin
            rdbuf <= done_rdata;
            rem <= rem - 1'b1;
            st <= S_RPUSH;
          end
          S_WDATA: begin
            have <= 1'b0;
            fail_cnt <= fail_cnt + FAIL_W'(done_nack);
            rem <= rem - 1'b1;
            st <= (rem == CNT_W'(1)) ? S_STOP : S_WDATA;
          end
          S_STOP: st <= S_FIN;
          default: st <= st;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_seq_chk.sv
module i2c_mem_seq_chk #(
  parameter int FAIL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [7:0]        cmd_byte,
  input logic              cmd_nack,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [7:0]        rd_data,
  input logic              wr_ready,
  input logic [FAIL_W-1:0] fail_cnt
);
  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte) && $stable(cmd_nack));

  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  assert_no_cmd_while_rd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cmd_valid);

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid && !rd_valid && !wr_ready);

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_fail_mono_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> fail_cnt >= $past(fail_cnt));
endmodule

bind i2c_mem_seq i2c_mem_seq_chk #(.FAIL_W(FAIL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .cmd_byte(cmd_byte), .cmd_nack(cmd_nack), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .wr_ready(wr_ready),
  .fail_cnt(fail_cnt)
);

// File: tb/i2c_mem_seq_tb_top.sv
module i2c_mem_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 0, rep_start = 0;
  logic [1:0] op = 0;
  logic [6:0] dev_addr = 0, ovf_mask = 0;
  logic [31:0] mem_addr = 0;
  logic [2:0] alen = 0;
  logic [7:0] nbytes = 0;
  logic busy, done, err, present;
  logic [7:0] fail_cnt;
  logic cmd_valid, cmd_nack;
  logic cmd_ready = 1'b1;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic cmd_done = 0, done_nack = 0;
  logic [7:0] done_rdata = 0;
  logic rd_valid, wr_ready;
  logic rd_ready = 1'b1;
  logic [7:0] rd_data;
  logic wr_valid = 0;
  logic [7:0] wr_data = 0;

  i2c_mem_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dev_addr(dev_addr),
    .mem_addr(mem_addr), .alen(alen), .nbytes(nbytes), .rep_start(rep_start),
    .ovf_mask(ovf_mask), .busy(busy), .done(done), .err(err), .present(present),
    .fail_cnt(fail_cnt), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
    .cmd_done(cmd_done), .done_nack(done_nack), .done_rdata(done_rdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data)
  );

  int errors = 0, checks = 0;
  string tag = "R0";
  logic [10:0] cq[$];
  logic [7:0] rq[$];
  logic [7:0] wq[$];
  logic [15:0] nack_mask = 0;
  int widx = 0, ridx = 0;
  logic stall = 0;
  int phase = 0, lat = 0, cyc = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void e_start(); cq.push_back({2'd0, 8'h00, 1'b0}); endfunction
  function automatic void e_stop();  cq.push_back({2'd1, 8'h00, 1'b0}); endfunction
  function automatic void e_wr(input logic [7:0] b); cq.push_back({2'd2, b, 1'b0}); endfunction
  function automatic void e_rd(input bit last); cq.push_back({2'd3, 8'h00, last}); endfunction

  always @(negedge clk) begin
    cyc++;
    cmd_done = 0;
    if (phase == 1) begin
      cmd_ready = 0;
      if (lat == 0) begin
        cmd_done = 1;
        phase = 0;
        cmd_ready = 1;
      end else lat--;
    end
    rd_ready = stall ? (cyc % 4 == 0) : 1'b1;
    wr_valid = (wq.size() > 0);
    wr_data = (wq.size() > 0) ? wq[0] : 8'h00;
    if (phase == 0 && !cmd_done && cmd_valid && cmd_ready) begin
      if (cq.size() == 0) begin
        chk(0, "unexpected command", {cmd_op, cmd_byte, cmd_nack}, 0);
      end else begin
        logic [10:0] e;
        e = cq.pop_front();
        chk({cmd_op, cmd_byte, cmd_nack} == e, "command {op,byte,nack}", {cmd_op, cmd_byte, cmd_nack}, e);
      end
      done_nack = 0;
      if (cmd_op == 2'd2) begin
        done_nack = nack_mask[widx];
        widx++;
      end
      if (cmd_op == 2'd3) begin
        done_rdata = 8'hA0 + 8'(ridx);
        ridx++;
      end
      phase = 1;
      lat = 2;
    end
    if (wr_valid && wr_ready) void'(wq.pop_front());
    if (rd_valid && rd_ready) begin
      if (rq.size() == 0) chk(0, "unexpected read byte", rd_data, 0);
      else begin
        logic [7:0] r;
        r = rq.pop_front();
        chk(rd_data == r, "read byte", rd_data, r);
      end
    end
  end

  task automatic go(input logic [1:0] o, input logic [6:0] d, input logic [31:0] a,
                    input logic [2:0] al, input logic [7:0] n, input logic rs,
                    input logic [6:0] m, input logic [15:0] nm);
    @(negedge clk);
    nack_mask = nm; widx = 0; ridx = 0;
    op = o; dev_addr = d; mem_addr = a; alen = al; nbytes = n; rep_start = rs; ovf_mask = m;
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    chk(cq.size() == 0, "commands left unissued", cq.size(), 0);
    chk(rq.size() == 0, "read bytes left undelivered", rq.size(), 0);
  endtask

  task automatic status(input bit e_err, input bit e_pres, input int e_fail);
    chk(err == e_err, "err", err, e_err);
    chk(present == e_pres, "present", present, e_pres);
    chk(fail_cnt == 8'(e_fail), "fail_cnt", fail_cnt, e_fail);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R13";
    chk(!busy && !done && !cmd_valid && !rd_valid && !wr_ready, "reset idle outputs",
        {busy, done, cmd_valid, rd_valid, wr_ready}, 0);
    status(0, 0, 0);

    tag = "R1"; // probe acked
    e_start(); e_wr(8'hA0); e_stop();
    go(2'b00, 7'h50, 0, 0, 0, 0, 7'h7F, 16'h0);
    status(0, 1, 0);
    tag = "R13"; // status held after done
    repeat (5) @(negedge clk);
    chk(present && !busy && !done, "status held idle", {present, busy, done}, 3'b100);

    tag = "R1"; // probe nacked
    e_start(); e_wr(8'hA0); e_stop();
    go(2'b00, 7'h50, 0, 0, 0, 0, 0, 16'h1);
    status(1, 0, 0);

    tag = "R4"; // write, two address bytes MSB first
    e_start(); e_wr(8'hA0); e_wr(8'h12); e_wr(8'h34);
    e_wr(8'h11); e_wr(8'h22); e_wr(8'h33); e_stop();
    wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33);
    go(2'b10, 7'h50, 32'h1234, 2, 3, 0, 0, 16'h0);
    status(0, 0, 0);

    tag = "R6"; // data NACKs counted, transfer continues
    e_start(); e_wr(8'hA0); e_wr(8'h12); e_wr(8'h34);
    e_wr(8'h44); e_wr(8'h55); e_wr(8'h66); e_stop();
    wq.push_back(8'h44); wq.push_back(8'h55); wq.push_back(8'h66);
    go(2'b10, 7'h50, 32'h1234, 2, 3, 0, 0, 16'h0028);
    status(0, 0, 2);

    tag = "R3"; // device NACK on write
    e_start(); e_wr(8'hA0); e_stop();
    wq.push_back(8'h77);
    go(2'b11, 7'h50, 32'h1234, 2, 1, 0, 0, 16'h1);
    status(1, 0, 0);
    wq.delete();

    tag = "R5"; // address byte NACK, no STOP
    e_start(); e_wr(8'hA0); e_wr(8'h12);
    wq.push_back(8'h77);
    go(2'b10, 7'h50, 32'h1234, 2, 1, 0, 0, 16'h2);
    status(1, 0, 0);
    repeat (10) @(negedge clk);
    chk(!busy && !cmd_valid, "no command after address NACK", {busy, cmd_valid}, 0);
    wq.delete();

    tag = "R7"; // read with no address, DEVR NACK ignored (R9)
    e_start(); e_wr(8'hA1); e_rd(0); e_rd(1); e_stop();
    rq.push_back(8'hA0); rq.push_back(8'hA1);
    go(2'b01, 7'h50, 0, 0, 2, 0, 0, 16'h1);
    status(0, 0, 0);

    tag = "R8"; // STOP+START default
    e_start(); e_wr(8'hA0); e_wr(8'h07); e_stop(); e_start(); e_wr(8'hA1);
    e_rd(0); e_rd(1); e_stop();
    rq.push_back(8'hA0); rq.push_back(8'hA1);
    go(2'b01, 7'h50, 32'h07, 1, 2, 0, 0, 16'h0);
    status(0, 0, 0);

    tag = "R12"; // repeated START with read back-pressure; R9 ack pattern
    stall = 1;
    e_start(); e_wr(8'hA0); e_wr(8'h07); e_start(); e_wr(8'hA1);
    e_rd(0); e_rd(0); e_rd(1); e_stop();
    rq.push_back(8'hA0); rq.push_back(8'hA1); rq.push_back(8'hA2);
    go(2'b01, 7'h50, 32'h07, 1, 3, 1, 0, 16'h0);
    status(0, 0, 0);
    stall = 0;

    tag = "R10"; // zero-count read
    e_start(); e_wr(8'hA0); e_wr(8'h07); e_stop(); e_start(); e_wr(8'hA1); e_stop();
    go(2'b01, 7'h50, 32'h07, 1, 0, 0, 0, 16'h0);
    status(0, 0, 0);

    tag = "R4"; // four address bytes on a read
    e_start(); e_wr(8'hA0); e_wr(8'h11); e_wr(8'h22); e_wr(8'h33); e_wr(8'h44);
    e_stop(); e_start(); e_wr(8'hA1); e_rd(1); e_stop();
    rq.push_back(8'hA0);
    go(2'b01, 7'h50, 32'h11223344, 4, 1, 0, 0, 16'h0);
    status(0, 0, 0);

    tag = "R3"; // device NACK in read pointer phase
    e_start(); e_wr(8'hA0); e_stop();
    go(2'b01, 7'h50, 32'h07, 1, 2, 0, 0, 16'h1);
    status(1, 0, 0);

    tag = "R11"; // overflow bits folded: 0x50 | (0xE & 3) = 0x52
    e_start(); e_wr(8'hA4); e_wr(8'hA5); e_wr(8'h5A); e_stop();
    wq.push_back(8'h5A);
    go(2'b10, 7'h50, 32'hEA5, 1, 1, 0, 7'h03, 16'h0);
    status(0, 0, 0);

    tag = "R11"; // overflow fold on read phase as well
    e_start(); e_wr(8'hA4); e_wr(8'hA5); e_start(); e_wr(8'hA5); e_rd(1); e_stop();
    rq.push_back(8'hA0);
    go(2'b01, 7'h50, 32'h2A5, 1, 1, 1, 7'h03, 16'h0);
    status(0, 0, 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule